// File: doc/BRIEF.md
# Maskable Vectored Interrupt Controller

This block gathers interrupt requests and picks the one the processor services next. It has three kinds of source. Six external lines are asynchronous and edge-triggered, each with its own polarity choice. Seven internal sources are single-cycle pulses from on-chip peripherals. The last is a software break request. Every maskable source keeps a request flag and an enable bit, and one global mask flag gates all of them. The break source ignores every mask.

The processor sees a valid flag and a vector index. When it accepts the interrupt it pulses `take`. In that same clock the block sets the global mask and clears the flag of the source it took. A separate `gdClear` pulse lifts the global mask when the handler returns. Software uses a small register port to write the enables and polarities, to clear request flags, and to read back all of this state. Software can never set a request flag.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every request flag, enable bit and polarity bit is 0. The break flag is 0, the global mask is 1 and `irqValid` is 0.
- R2: A maskable source raises `irqValid` only when its request flag is 1, its enable bit is 1 and the global mask is 0.
- R3: A write to the request register (address 2) ANDs the data into the flags. A 0 bit clears its flag, and a 1 bit leaves the flag as it was, so a clear flag is never set by a write.
- R4: A pending break raises `irqValid` with vector 0 whatever the global mask and enable bits hold. Status register (address 3) bit 1 shows the break flag and bit 0 shows the global mask.
- R5: Priority is fixed. The break comes first with vector 0. External line k follows with vector k+1, then internal source j with vector 7+j. Among pending sources the lower vector wins.
- R6: A `take` pulse while `irqValid` is 1 sets the global mask and clears the winner's flag in the same clock. No other flag changes. A `take` while `irqValid` is 0 has no effect.
- R7: External line k sets request bit k. Polarity bit k (address 1) selects the edge: 0 for rising, 1 for falling. The input passes through two synchronizer flops, so the flag reads 1 after the third rising clock edge that follows the input change.
- R8: Writing a polarity bit so that (line XOR polarity) goes from 0 to 1 counts as an edge. The flag sets one clock after the write takes effect.
- R9: If a hardware set and a software clear of the same flag fall in the same clock, the flag ends up 1.
- R10: `gdClear` clears the global mask in the next clock. If `take` is accepted in the same clock, the mask ends up 1.
- R11: An internal pulse j that is high at a rising clock edge sets request bit 6+j at that edge.
- R12: The enable register (address 0, bit layout matching the request flags) can be written to any value, and it reads back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extIn | input | 6 | Asynchronous external interrupt lines |
| intPulse | input | 7 | Single-cycle internal request pulses |
| brkReq | input | 1 | Software break request pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for write and read (0 enable, 1 polarity, 2 request, 3 status) |
| regWrData | input | 13 | Register write data |
| regRdData | output | 13 | Read data of the selected register |
| take | input | 1 | Processor accepts the current interrupt |
| gdClear | input | 1 | Processor clears the global mask |
| irqValid | output | 1 | A takeable interrupt is pending |
| irqVector | output | 4 | Vector index of the winning source |

## Verification
The bench writes all-ones to the request register and confirms that a clear flag stays clear. A design that ORed the write data into the flags would set it. It changes a polarity bit while its line sits low and expects a request. A detector that compared raw synchronized samples would miss this spurious edge. Other checks sample an external edge exactly at the third clock edge, collide an internal pulse with a software clear, collide `take` with `gdClear`, and raise a break while every mask is active. Each of these exposes a wrong latency, the wrong winner of a collision, or a break that obeys the mask.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  // Register select codes shared by the write and read paths.
  typedef enum logic [1:0] {
    REG_ENABLE   = 2'd0,
    REG_POLARITY = 2'd1,
    REG_REQUEST  = 2'd2,
    REG_STATUS   = 2'd3
  } reg_sel_e;

  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic wrEnable;
    logic wrPolarity;
    logic wrRequest;
    logic ackBreak;
    logic ackMaskable;
    logic setMask;
    logic clrMask;
  } strobe_t;

endpackage

// File: rtl/vec_irq_edge.sv
module vec_irq_edge #(
  parameter int NUM_EXT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] lineIn,
  input  logic [NUM_EXT-1:0] polarity,
  output logic [NUM_EXT-1:0] edgeHit
);

  genvar k;
  generate
    for (k = 0; k < NUM_EXT; k++) begin : g_line
      logic syncA;
      logic syncB;
      logic levelPrev;
      logic level;

      // Polarity is folded in before the history flop, so flipping it
      // can produce an edge of its own.
      assign level = syncB ^ polarity[k];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA     <= 1'b0;
          syncB     <= 1'b0;
          levelPrev <= 1'b0;
        end else begin
          syncA     <= lineIn[k];
          syncB     <= syncA;
          levelPrev <= level;
        end
      end

      assign edgeHit[k] = level & ~levelPrev;
    end
  endgenerate

endmodule

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int NUM_EXT = 6,
  parameter int NUM_INT = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [NUM_EXT+NUM_INT-1:0]    wrData,
  input  logic [NUM_EXT+NUM_INT-1:0]    winOh,
  input  logic [NUM_EXT-1:0]            edgeHit,
  input  logic [NUM_INT-1:0]            intPulse,
  input  logic                          brkReq,
  input  logic [1:0]                    rdSel,
  output logic [NUM_EXT+NUM_INT-1:0]    reqQ,
  output logic [NUM_EXT+NUM_INT-1:0]    enQ,
  output logic [NUM_EXT-1:0]            polQ,
  output logic                          brkQ,
  output logic                          maskQ,
  output logic [NUM_EXT+NUM_INT-1:0]    rdData
);

  localparam int NUM_MASK = NUM_EXT + NUM_INT;

  logic [NUM_MASK-1:0] reqNext;
  logic [NUM_MASK-1:0] hwSet;

  assign hwSet = {intPulse, edgeHit};

  // Software clear and take clear first, hardware set last so it wins.
  always_comb begin
    reqNext = reqQ;
    if (stb.wrRequest)   reqNext = reqNext & wrData;
    if (stb.ackMaskable) reqNext = reqNext & ~winOh;
    reqNext = reqNext | hwSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ  <= '0;
      enQ   <= '0;
      polQ  <= '0;
      brkQ  <= 1'b0;
      maskQ <= 1'b1;
    end else begin
      reqQ <= reqNext;
      if (stb.wrEnable)   enQ  <= wrData;
      if (stb.wrPolarity) polQ <= wrData[NUM_EXT-1:0];
      brkQ <= brkReq | (brkQ & ~stb.ackBreak);
      if (stb.setMask)      maskQ <= 1'b1;
      else if (stb.clrMask) maskQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (reg_sel_e'(rdSel))
      REG_ENABLE:   rdData = enQ;
      REG_POLARITY: rdData[NUM_EXT-1:0] = polQ;
      REG_REQUEST:  rdData = reqQ;
      REG_STATUS:   rdData[1:0] = {brkQ, maskQ};
      default:      rdData = '0;
    endcase
  end

endmodule

// File: rtl/vec_irq_control.sv
module vec_irq_control
  import vec_irq_pkg::*;
#(
  parameter int NUM_EXT = 6,
  parameter int NUM_INT = 7
) (
  input  logic                                 regWrEn,
  input  logic [1:0]                           regAddr,
  input  logic                                 take,
  input  logic                                 gdClear,
  input  logic [NUM_EXT+NUM_INT-1:0]           reqQ,
  input  logic [NUM_EXT+NUM_INT-1:0]           enQ,
  input  logic                                 maskQ,
  input  logic                                 brkQ,
  output strobe_t                              stb,
  output logic [NUM_EXT+NUM_INT-1:0]           winOh,
  output logic                                 irqValid,
  output logic [$clog2(NUM_EXT+NUM_INT+1)-1:0] irqVector
);

  localparam int NUM_MASK = NUM_EXT + NUM_INT;
  localparam int VEC_W    = $clog2(NUM_MASK + 1);

  logic [NUM_MASK-1:0] pend;
  logic [VEC_W-1:0]    winVec;
  logic                anyPend;
  logic                takeOk;
  reg_sel_e            sel;

  assign pend = reqQ & enQ & {NUM_MASK{~maskQ}};

  // Lowest index wins: scan from the top so the last hit stands.
  always_comb begin
    winOh   = '0;
    winVec  = '0;
    anyPend = 1'b0;
    for (int i = NUM_MASK - 1; i >= 0; i--) begin
      if (pend[i]) begin
        winOh    = '0;
        winOh[i] = 1'b1;
        winVec   = VEC_W'(i + 1);
        anyPend  = 1'b1;
      end
    end
  end

  assign irqValid  = brkQ | anyPend;
  assign irqVector = brkQ ? '0 : winVec;
  assign takeOk    = take & irqValid;
  assign sel       = reg_sel_e'(regAddr);

  always_comb begin
    stb             = '0;
    stb.wrEnable    = regWrEn && (sel == REG_ENABLE);
    stb.wrPolarity  = regWrEn && (sel == REG_POLARITY);
    stb.wrRequest   = regWrEn && (sel == REG_REQUEST);
    stb.ackBreak    = takeOk & brkQ;
    stb.ackMaskable = takeOk & ~brkQ;
    stb.setMask     = takeOk;
    stb.clrMask     = gdClear;
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_EXT = 6,
  parameter int NUM_INT = 7,
  localparam int NUM_MASK = NUM_EXT + NUM_INT,
  localparam int VEC_W    = $clog2(NUM_MASK + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXT-1:0]  extIn,
  input  logic [NUM_INT-1:0]  intPulse,
  input  logic                brkReq,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [NUM_MASK-1:0] regWrData,
  output logic [NUM_MASK-1:0] regRdData,
  input  logic                take,
  input  logic                gdClear,
  output logic                irqValid,
  output logic [VEC_W-1:0]    irqVector
);

  strobe_t             stb;
  logic [NUM_MASK-1:0] winOh;
  logic [NUM_EXT-1:0]  edgeHit;
  logic [NUM_MASK-1:0] reqQ;
  logic [NUM_MASK-1:0] enQ;
  logic [NUM_EXT-1:0]  polQ;
  logic                brkQ;
  logic                maskQ;

  vec_irq_edge #(.NUM_EXT(NUM_EXT)) u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (extIn),
    .polarity (polQ),
    .edgeHit  (edgeHit)
  );

  vec_irq_datapath #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .winOh    (winOh),
    .edgeHit  (edgeHit),
    .intPulse (intPulse),
    .brkReq   (brkReq),
    .rdSel    (regAddr),
    .reqQ     (reqQ),
    .enQ      (enQ),
    .polQ     (polQ),
    .brkQ     (brkQ),
    .maskQ    (maskQ),
    .rdData   (regRdData)
  );

  vec_irq_control #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) u_ctl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .take      (take),
    .gdClear   (gdClear),
    .reqQ      (reqQ),
    .enQ       (enQ),
    .maskQ     (maskQ),
    .brkQ      (brkQ),
    .stb       (stb),
    .winOh     (winOh),
    .irqValid  (irqValid),
    .irqVector (irqVector)
  );

endmodule

// File: rtl/vec_irq_checker.sv
module vec_irq_checker #(
  parameter int NUM_EXT = 6,
  parameter int NUM_INT = 7,
  localparam int NUM_MASK = NUM_EXT + NUM_INT,
  localparam int VEC_W    = $clog2(NUM_MASK + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                take,
  input logic                gdClear,
  input logic [NUM_INT-1:0]  intPulse,
  input logic                irqValid,
  input logic [VEC_W-1:0]    irqVector,
  input logic [NUM_MASK-1:0] reqQ,
  input logic [NUM_MASK-1:0] enQ,
  input logic                maskQ,
  input logic                brkQ
);

  assert_grant_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !brkQ) |-> (!maskQ && ((reqQ & enQ) != '0)));

  assert_break_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    brkQ |-> (irqValid && irqVector == '0));

  assert_vector_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (int'(irqVector) <= NUM_MASK));

  assert_take_masks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (take && irqValid) |=> maskQ);

  assert_unmask_R10: assert property (@(posedge clk) disable iff (!rstN)
    (gdClear && !(take && irqValid)) |=> !maskQ);

  // Internal flags rise only from a pulse, never from a register write (R3, R11).
  assert_no_soft_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((reqQ[NUM_MASK-1:NUM_EXT] & ~$past(reqQ[NUM_MASK-1:NUM_EXT])
              & ~$past(intPulse)) == '0));

endmodule

bind vec_irq_ctrl vec_irq_checker #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .take      (take),
  .gdClear   (gdClear),
  .intPulse  (intPulse),
  .irqValid  (irqValid),
  .irqVector (irqVector),
  .reqQ      (reqQ),
  .enQ       (enQ),
  .maskQ     (maskQ),
  .brkQ      (brkQ)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  extIn = '0;
  logic [6:0]  intPulse = '0;
  logic        brkReq = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [12:0] regWrData = '0;
  logic [12:0] regRdData;
  logic        take = 1'b0;
  logic        gdClear = 1'b0;
  logic        irqValid;
  logic [3:0]  irqVector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string tag;
    int    kind;  // 0: {valid,vector}, 1: read data
    int    exp;
  } item_t;

  item_t sbq[$];
  item_t cur;

  always #5 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .extIn(extIn), .intPulse(intPulse),
    .brkReq(brkReq), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .take(take),
    .gdClear(gdClear), .irqValid(irqValid), .irqVector(irqVector)
  );

  // Monitor: pops expected items and compares them 1 ns later.
  initial begin
    forever begin
      int act;
      wait (sbq.size() > 0);
      #1;
      cur = sbq.pop_front();
      act = (cur.kind == 0) ? (int'(irqValid) * 16 + int'(irqVector)) : int'(regRdData);
      checks++;
      if (act != cur.exp) begin
        fails++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic expectItem(string tag, int kind, int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkIrq(string tag, int valid, int vec);
    expectItem(tag, 0, valid * 16 + vec);
  endtask

  task automatic chkReg(string tag, int addr, int exp);
    regAddr = 2'(addr);
    expectItem(tag, 1, exp);
  endtask

  task automatic wr(int addr, int data);
    regWrEn = 1'b1; regAddr = 2'(addr); regWrData = 13'(data);
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic pulseInt(int idx);
    intPulse[idx] = 1'b1; tick(1); intPulse = '0;
  endtask

  task automatic doTake();
    take = 1'b1; tick(1); take = 1'b0;
  endtask

  task automatic doUnmask();
    gdClear = 1'b1; tick(1); gdClear = 1'b0;
  endtask

  task automatic doBreak();
    brkReq = 1'b1; tick(1); brkReq = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chkReg("R1 status", 3, 1);
    chkReg("R1 request", 2, 0);
    chkReg("R1 enable", 0, 0);
    chkReg("R1 polarity", 1, 0);
    chkIrq("R1 idle", 0, 0);

    // R12 enable register both ways
    wr(0, 13'h1FFF); chkReg("R12 all ones", 0, 13'h1FFF);
    wr(0, 0);        chkReg("R12 zero", 0, 0);

    // R11 internal pulse, R2 gating
    pulseInt(2);
    chkReg("R11 flag set", 2, 13'h100);
    chkIrq("R2 disabled", 0, 0);
    wr(0, 13'h100);
    chkIrq("R2 masked", 0, 0);
    doUnmask();
    chkIrq("R2 granted", 1, 9);

    // R3 ones do not set
    wr(2, 13'h1FFF);
    chkReg("R3 ones keep", 2, 13'h100);

    // R5 internal priority
    pulseInt(0);
    wr(0, 13'h140);
    chkIrq("R5 int0 over int2", 1, 7);

    // R6 take
    doTake();
    chkIrq("R6 masked after take", 0, 0);
    chkReg("R6 winner cleared", 2, 13'h100);
    chkReg("R6 mask set", 3, 1);
    doUnmask();
    chkIrq("R10 unmask", 1, 9);

    // R3 zero clears
    wr(2, 0);
    chkReg("R3 cleared", 2, 0);
    chkIrq("R3 idle", 0, 0);

    // R9 set beats clear
    intPulse[3] = 1'b1;
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = '0;
    tick(1);
    intPulse = '0; regWrEn = 1'b0;
    chkReg("R9 set wins", 2, 13'h200);
    wr(2, 0);

    // R4 break ignores masks
    doBreak();
    chkIrq("R4 break", 1, 0);
    chkReg("R4 status", 3, 2);
    doTake();
    chkReg("R4 break taken", 3, 1);
    chkIrq("R4 idle", 0, 0);
    wr(0, 0);
    doBreak();
    chkIrq("R4 break masked all", 1, 0);
    doTake();
    chkReg("R4 taken again", 3, 1);

    // R7 rising edge latency
    wr(0, 13'h002);
    doUnmask();
    chkReg("R10 status", 3, 0);
    extIn[1] = 1'b1;
    tick(2);
    chkReg("R7 not yet", 2, 0);
    tick(1);
    chkReg("R7 rising set", 2, 13'h002);
    chkIrq("R7 vector", 1, 2);
    doTake();
    extIn[1] = 1'b0;
    tick(4);
    chkReg("R7 falling ignored", 2, 0);

    // R8 polarity change edge
    wr(1, 13'h002);
    chkReg("R8 not yet", 2, 0);
    tick(1);
    chkReg("R8 spurious", 2, 13'h002);
    wr(2, 0);
    extIn[1] = 1'b1;
    tick(4);
    chkReg("R7 rising ignored", 2, 0);
    extIn[1] = 1'b0;
    tick(3);
    chkReg("R7 falling set", 2, 13'h002);

    // R5 external over internal, break over all
    pulseInt(0);
    wr(0, 13'h042);
    doUnmask();
    chkIrq("R5 ext over int", 1, 2);
    doBreak();
    chkIrq("R5 break first", 1, 0);
    doTake();
    doUnmask();
    chkIrq("R5 ext after break", 1, 2);

    // R10 take beats unmask
    take = 1'b1; gdClear = 1'b1;
    tick(1);
    take = 1'b0; gdClear = 1'b0;
    chkReg("R10 take wins", 3, 1);
    chkReg("R6 other kept", 2, 13'h040);
    chkIrq("R10 masked", 0, 0);

    // R6 take with nothing valid
    doTake();
    chkReg("R6 noop req", 2, 13'h040);
    chkReg("R6 noop status", 3, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule